// File: doc/BRIEF.md
# AC-link frame sync generator

This block is the timing engine on the controller end of an AC'97-style serial link. The incoming bit clock runs it. It counts bit positions through a frame of a 16-bit tag slot followed by twelve 20-bit slots, for 256 bits in all. It drives the frame SYNC line high over the tag slot and low for the rest of the frame, so SYNC is the bit clock divided by 256. Each rising SYNC edge opens a new frame.

On the outgoing side, a full parallel frame is taken in at the frame boundary. It is shifted onto the serial data line MSB first, and the line changes only on rising bit-clock edges. On the incoming side, the serial line is sampled on the falling edge that follows each launch edge. The bits are assembled into a parallel frame. That frame is handed over with a one-cycle valid pulse once its last bit is in.

A frame-start strobe, the current bit position and the current slot number let the surrounding logic line up payload handling with the link. The frame geometry is set by parameters: tag width, slot width, slot count and SYNC high time.

Top module: `ac_link_frame_gen`

## Requirements
- R1: `bit_pos` increases by one on every rising bit-clock edge and wraps from FRAME_BITS-1 to 0. FRAME_BITS is TAG_W + NUM_SLOTS*SLOT_W, which is 256 by default.
- R2: `sync` is 1 while `bit_pos` is below SYNC_HIGH (16 by default) and 0 for the other positions. It rises only as `bit_pos` becomes 0.
- R3: `frame_start` is 1 for exactly the one cycle in which `bit_pos` is 0.
- R4: While `bit_pos` is k, `sdata_out` carries bit FRAME_BITS-1-k of the outgoing frame, so the MSB goes first. The line changes only on rising edges.
- R5: `tx_frame` is sampled only on the rising edge that makes `bit_pos` 0. A change later in the frame does not alter the bits sent in that frame.
- R6: `sdata_in` is sampled on the falling edge inside bit position k, and that bit lands in `rx_frame[FRAME_BITS-1-k]`. The level present at the rising edges is ignored.
- R7: `rx_valid` pulses for one cycle while `bit_pos` is 0, with `rx_frame` holding the frame just completed. `rx_frame` does not change between pulses.
- R8: No `rx_valid` is given for the first frame boundary after reset, because no complete frame has been received before it.
- R9: `slot_idx` is 0 over the tag positions 0..TAG_W-1. Over positions TAG_W+(n-1)*SLOT_W through TAG_W+n*SLOT_W-1 it is n, for n from 1 to NUM_SLOTS.
- R10: Reset is asynchronous and active-low. While `rst_n` is low, `sync`, `sdata_out`, `frame_start` and `rx_valid` are 0, `bit_pos` is FRAME_BITS-1 and `slot_idx` is NUM_SLOTS. Release passes through a two-stage synchronizer, so `bit_pos` first becomes 0 on the third rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; rising edge launches, falling edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_frame | input | FRAME_BITS | Outgoing frame, bit FRAME_BITS-1 sent first |
| sdata_in | input | 1 | Incoming serial data |
| sync | output | 1 | Frame SYNC, high over the first SYNC_HIGH bits |
| sdata_out | output | 1 | Outgoing serial data |
| frame_start | output | 1 | One-cycle strobe at bit position 0 |
| bit_pos | output | CNT_W | Current bit position in the frame |
| slot_idx | output | SLOT_IDX_W | Current slot, 0 for the tag slot |
| rx_frame | output | FRAME_BITS | Last complete received frame |
| rx_valid | output | 1 | One-cycle pulse when rx_frame is updated |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots and SYNC high for 16 bits. This gives the full 256-bit frame, so every slot boundary, the SYNC fall at bit 16 and the wrap from 255 to 0 fall within a few frames. With these values the slot index climbs through all thirteen values, and several 32-bit patterns repeated across the frame test MSB-first ordering in both directions. The incoming line is inverted after each falling edge, which separates falling-edge sampling from rising-edge sampling.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int unsigned DEF_TAG_W     = 16;
  localparam int unsigned DEF_SLOT_W    = 20;
  localparam int unsigned DEF_NUM_SLOTS = 12;

  // Phase of the frame: inside the tag slot or inside a data slot.
  typedef enum logic {
    PH_TAG  = 1'b0,
    PH_DATA = 1'b1
  } aclk_phase_e;

  function automatic int unsigned frame_len(input int unsigned tag_w,
                                            input int unsigned slot_w,
                                            input int unsigned n_slots);
    return tag_w + n_slots * slot_w;
  endfunction

endpackage

// File: rtl/aclk_rst_sync.sv
module aclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = pipe_q[STAGES-1];

endmodule

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer
  import aclk_pkg::*;
#(
  parameter  int unsigned TAG_W      = DEF_TAG_W,
  parameter  int unsigned SLOT_W     = DEF_SLOT_W,
  parameter  int unsigned NUM_SLOTS  = DEF_NUM_SLOTS,
  parameter  int unsigned SYNC_HIGH  = TAG_W,
  localparam int unsigned FRAME_BITS = frame_len(TAG_W, SLOT_W, NUM_SLOTS),
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [CNT_W-1:0]      bit_pos,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic                  sync,
  output logic                  frame_start,
  output logic                  wrap
);

  localparam int unsigned SBIT_W = $clog2(((TAG_W > SLOT_W) ? TAG_W : SLOT_W) + 1);

  localparam logic [CNT_W-1:0]      LAST_C    = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]      CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W:0]        SYNC_C    = (CNT_W + 1)'(SYNC_HIGH);
  localparam logic [SBIT_W-1:0]     TAG_LAST  = SBIT_W'(TAG_W - 1);
  localparam logic [SBIT_W-1:0]     SLOT_LAST = SBIT_W'(SLOT_W - 1);
  localparam logic [SBIT_W-1:0]     SBIT_ONE  = SBIT_W'(1);
  localparam logic [SLOT_IDX_W-1:0] SLOT_ONE  = SLOT_IDX_W'(1);
  localparam logic [SLOT_IDX_W-1:0] SLOT_MAX  = SLOT_IDX_W'(NUM_SLOTS);

  logic [CNT_W-1:0]      cnt_q,   cnt_d;
  logic [SLOT_IDX_W-1:0] slot_q,  slot_d;
  logic [SBIT_W-1:0]     sbit_q,  sbit_d;
  aclk_phase_e           phase_q, phase_d;
  logic                  sync_q,  sync_d;
  logic                  start_q, start_d;
  logic                  cnt_wrap;
  logic                  slot_end;

  // Next-state logic
  always_comb begin
    cnt_wrap = (cnt_q == LAST_C);
    cnt_d    = cnt_wrap ? '0 : (cnt_q + CNT_ONE);

    slot_end = (phase_q == PH_TAG) ? (sbit_q == TAG_LAST) : (sbit_q == SLOT_LAST);
    slot_d   = slot_q;
    sbit_d   = sbit_q + SBIT_ONE;
    phase_d  = phase_q;
    if (cnt_wrap) begin
      slot_d  = '0;
      sbit_d  = '0;
      phase_d = PH_TAG;
    end else if (slot_end) begin
      slot_d  = slot_q + SLOT_ONE;
      sbit_d  = '0;
      phase_d = PH_DATA;
    end

    sync_d  = ({1'b0, cnt_d} < SYNC_C);
    start_d = cnt_wrap;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= LAST_C;
      slot_q  <= SLOT_MAX;
      sbit_q  <= SLOT_LAST;
      phase_q <= PH_DATA;
      sync_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      sbit_q  <= sbit_d;
      phase_q <= phase_d;
      sync_q  <= sync_d;
      start_q <= start_d;
    end
  end

  assign bit_pos     = cnt_q;
  assign slot_idx    = slot_q;
  assign sync        = sync_q;
  assign frame_start = start_q;
  assign wrap        = cnt_wrap;

  // Bit position advances by one per rising edge (R1)
  p_bitpos_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST_C) |=> (cnt_q == ($past(cnt_q) + CNT_ONE)));

  p_bitpos_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST_C) |=> (cnt_q == '0));

  // SYNC window follows the bit position (R2)
  p_sync_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q == ({1'b0, cnt_q} < SYNC_C));

  p_sync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> (cnt_q == '0));

  // Frame strobe only at position zero and never twice in a row (R3)
  p_start_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == '0));

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // Tag slot coincides with the first TAG_W positions (R9)
  p_slot_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == '0) == ({1'b0, cnt_q} < (CNT_W + 1)'(TAG_W)));

endmodule

// File: rtl/aclk_tx_shifter.sv
module aclk_tx_shifter #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] tx_frame,
  output logic                  sdata_out
);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  shift_en;

  always_comb begin
    shift_en = !load;
    sh_d     = sh_q;
    if (load) begin
      sh_d = tx_frame;
    end else if (shift_en) begin
      sh_d = {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign sdata_out = sh_q[FRAME_BITS-1];

  // First bit on the line after a load is the frame MSB (R4)
  p_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdata_out == $past(tx_frame[FRAME_BITS-1])));

endmodule

// File: rtl/aclk_rx_capture.sv
module aclk_rx_capture #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sdata_in,
  input  logic                  frame_end,
  output logic [FRAME_BITS-1:0] rx_frame,
  output logic                  rx_valid
);

  logic                  smp_q;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic                  armed_q, armed_d;
  logic                  valid_q, valid_d;
  logic                  frm_en;

  // Falling-edge sample of the serial line
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
    end else begin
      smp_q <= sdata_in;
    end
  end

  always_comb begin
    sh_d    = {sh_q[FRAME_BITS-2:0], smp_q};
    frm_en  = frame_end && armed_q;
    frm_d   = frm_en ? sh_d : frm_q;
    valid_d = frm_en;
    armed_d = armed_q | frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      frm_q   <= '0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      frm_q   <= frm_d;
      armed_q <= armed_d;
      valid_q <= valid_d;
    end
  end

  assign rx_frame = frm_q;
  assign rx_valid = valid_q;

  // Valid is a single-cycle pulse and the frame holds between pulses (R7)
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(frm_q));

  // No hand-over before a whole frame has been seen (R8)
  p_valid_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(armed_q));

endmodule

// File: rtl/ac_link_frame_gen.sv
module ac_link_frame_gen
  import aclk_pkg::*;
#(
  parameter  int unsigned TAG_W      = DEF_TAG_W,
  parameter  int unsigned SLOT_W     = DEF_SLOT_W,
  parameter  int unsigned NUM_SLOTS  = DEF_NUM_SLOTS,
  parameter  int unsigned SYNC_HIGH  = TAG_W,
  localparam int unsigned FRAME_BITS = frame_len(TAG_W, SLOT_W, NUM_SLOTS),
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
  localparam int unsigned SLOT_IDX_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                  bit_clk,
  input  logic                  rst_n,
  input  logic [FRAME_BITS-1:0] tx_frame,
  input  logic                  sdata_in,
  output logic                  sync,
  output logic                  sdata_out,
  output logic                  frame_start,
  output logic [CNT_W-1:0]      bit_pos,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [FRAME_BITS-1:0] rx_frame,
  output logic                  rx_valid
);

  logic rst_n_s;
  logic wrap;

  aclk_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk     (bit_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  aclk_frame_timer #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SYNC_HIGH (SYNC_HIGH)
  ) u_timer (
    .clk         (bit_clk),
    .rst_n       (rst_n_s),
    .bit_pos     (bit_pos),
    .slot_idx    (slot_idx),
    .sync        (sync),
    .frame_start (frame_start),
    .wrap        (wrap)
  );

  aclk_tx_shifter #(
    .FRAME_BITS (FRAME_BITS)
  ) u_tx (
    .clk       (bit_clk),
    .rst_n     (rst_n_s),
    .load      (wrap),
    .tx_frame  (tx_frame),
    .sdata_out (sdata_out)
  );

  aclk_rx_capture #(
    .FRAME_BITS (FRAME_BITS)
  ) u_rx (
    .clk       (bit_clk),
    .rst_n     (rst_n_s),
    .sdata_in  (sdata_in),
    .frame_end (wrap),
    .rx_frame  (rx_frame),
    .rx_valid  (rx_valid)
  );

endmodule

// File: tb/ac_link_frame_gen_bench.sv
`timescale 1ns/1ps
module ac_link_frame_gen_bench;

  localparam int FB = 256;

  logic          bit_clk = 1'b0;
  logic          rst_n;
  logic [FB-1:0] tx_frame;
  logic          sdata_in;
  logic          sync, sdata_out, frame_start, rx_valid;
  logic [7:0]    bit_pos;
  logic [3:0]    slot_idx;
  logic [FB-1:0] rx_frame;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 bit_clk = ~bit_clk;

  ac_link_frame_gen u_ac_link_frame_gen (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .tx_frame    (tx_frame),
    .sdata_in    (sdata_in),
    .sync        (sync),
    .sdata_out   (sdata_out),
    .frame_start (frame_start),
    .bit_pos     (bit_pos),
    .slot_idx    (slot_idx),
    .rx_frame    (rx_frame),
    .rx_valid    (rx_valid)
  );

  // {tx seed, rx seed, change tx_frame mid-frame}
  localparam logic [64:0] VECS [6] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
    {32'h1234_5678, 32'h8000_0001, 1'b1},
    {32'h0F0F_F0F0, 32'hDEAD_BEEF, 1'b0},
    {32'h8000_0001, 32'h0123_4567, 1'b0}
  };

  function automatic logic [FB-1:0] expand(input logic [31:0] seed);
    return {8{seed}};
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Entered at a falling edge while bit_pos is FB-1; leaves in the same state.
  task automatic run_frame(input logic [FB-1:0] tx, input logic [FB-1:0] rx,
                           input bit perturb, input bit exp_valid,
                           input logic [FB-1:0] exp_rx);
    int bad_pos = 0, bad_sync = 0, bad_start = 0, bad_sd = 0, bad_slot = 0, bad_val = 0;
    tx_frame = tx;
    for (int k = 0; k < FB; k++) begin
      @(posedge bit_clk);
      #1 sdata_in = rx[FB-1-k];
      @(negedge bit_clk);
      if (bit_pos !== 8'(k)) bad_pos++;
      if (sync !== (k < 16)) bad_sync++;
      if (frame_start !== (k == 0)) bad_start++;
      if (sdata_out !== tx[FB-1-k]) bad_sd++;
      if (slot_idx !== ((k < 16) ? 4'd0 : 4'(1 + (k - 16) / 20))) bad_slot++;
      if (k == 0) begin
        check_eq(exp_valid ? "R7" : "R8", "rx_valid at frame start",
                 FB'(rx_valid), FB'(exp_valid));
        if (exp_valid) check_eq("R6", "rx_frame contents", rx_frame, exp_rx);
      end else if (rx_valid !== 1'b0) begin
        bad_val++;
      end
      if (perturb && k == 8) tx_frame = ~tx;
      #1 sdata_in = ~rx[FB-1-k];
    end
    check_eq("R1", "bit_pos mismatches", FB'(bad_pos), '0);
    check_eq("R2", "sync mismatches", FB'(bad_sync), '0);
    check_eq("R3", "frame_start mismatches", FB'(bad_start), '0);
    check_eq(perturb ? "R5" : "R4", "sdata_out mismatches", FB'(bad_sd), '0);
    check_eq("R9", "slot_idx mismatches", FB'(bad_slot), '0);
    check_eq("R7", "rx_valid outside position 0", FB'(bad_val), '0);
  endtask

  task automatic check_reset_state(input string tag);
    check_eq("R10", {tag, " sync"}, FB'(sync), '0);
    check_eq("R10", {tag, " sdata_out"}, FB'(sdata_out), '0);
    check_eq("R10", {tag, " frame_start"}, FB'(frame_start), '0);
    check_eq("R10", {tag, " rx_valid"}, FB'(rx_valid), '0);
    check_eq("R10", {tag, " bit_pos"}, FB'(bit_pos), FB'(255));
    check_eq("R10", {tag, " slot_idx"}, FB'(slot_idx), FB'(12));
  endtask

  task automatic release_and_align();
    @(negedge bit_clk);
    rst_n = 1'b1;
    @(posedge bit_clk);
    @(posedge bit_clk);
    @(negedge bit_clk);
    check_eq("R10", "bit_pos held during release sync", FB'(bit_pos), FB'(255));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [FB-1:0] prev_rx;
    bit            have_prev;
    rst_n    = 1'b0;
    tx_frame = '0;
    sdata_in = 1'b0;
    prev_rx  = '0;
    have_prev = 0;

    repeat (3) @(negedge bit_clk);
    check_reset_state("power-on");
    release_and_align();

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      run_frame(expand(VECS[v][64:33]), expand(VECS[v][32:1]), VECS[v][0],
                have_prev, prev_rx);
      prev_rx   = expand(VECS[v][32:1]);
      have_prev = 1;
    end
    run_frame('0, '0, 1'b0, 1'b1, prev_rx);

    // Directed: asynchronous reset inside the SYNC-high window (R10)
    repeat (6) @(negedge bit_clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-frame");
    release_and_align();

    // First frame after reset must not hand over a stale frame (R8)
    run_frame(expand(32'hC3C3_C3C3), expand(32'h5A5A_5A5A), 1'b0, 1'b0, '0);
    run_frame(expand(32'h7E81_7E81), '0, 1'b0, 1'b1, expand(32'h5A5A_5A5A));

    finish_run();
  end

endmodule